// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between an HDLC deframer and a receive FIFO. It sees every received byte, together with flags marking the first and the last byte of a frame. It decides, one byte at a time, which bytes go on to the FIFO. A 3-bit mode input selects one of four behaviours:
- pass whole frames unchecked;
- filter on the first address byte, which is compared with two programmable values and two fixed group values;
- filter on the second address byte, which is compared with two programmable values and one fixed group value;
- raw bypass, in which every byte goes through and framing is ignored.

Any other mode code blocks all traffic.

Both the input and the output are valid/ready byte streams, and the path between them has no register in it. When the current byte is to be forwarded, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A stalled FIFO therefore stalls the deframer. When the current byte is to be dropped, `in_ready` is 1 and the byte is consumed with no output. On a forwarded byte, `in_ready` may depend on `in_valid` and on that byte's flags. Every forwarded byte carries a last flag and a 2-bit status. On the final byte of a filtered frame, the status reports which comparator accepted the frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: Mode 3'b110 forwards every byte of a frame, from the byte flagged start through the byte flagged end. `out_last` is 1 on the end byte, and `out_status` is 2'b00.
- R2: Mode 3'b111 compares the start byte with `cfg_sap1`, `cfg_sap2`, 8'hFE and 8'hFC. The start byte itself is never forwarded. On a match, the bytes after it are forwarded, up to and including the end byte.
- R3: Mode 3'b101 compares only the second byte of the frame with `cfg_tei1`, `cfg_tei2` and 8'hFF. The first two bytes are never forwarded. On a match, bytes from the third byte onward are forwarded.
- R4: In modes 3'b111 and 3'b101, a mismatch on the compared byte means nothing more of that frame is forwarded, and every one of its bytes is consumed.
- R5: On the end byte of a forwarded, filtered frame, `out_status` encodes the comparator that accepted it: 2'b01 for the first register, 2'b10 for the second register, 2'b11 for a group value. If several match, the first register wins over the second, and the second wins over a group value. On every other forwarded byte, `out_status` is 2'b00.
- R6: If the end byte arrives at or before the compared position, nothing of that frame is forwarded.
- R7: Mode 3'b100 forwards every accepted byte unchanged, whatever its start and end flags. `out_last` and `out_status` are 0 in this mode.
- R8: Mode codes 3'b000 through 3'b011 forward nothing, and every input byte is consumed.
- R9: In the framed modes, a byte that arrives with no frame open is not forwarded. A frame is open after a start byte and until its end byte; no frame is open after reset.
- R10: Every forwarded byte appears on `out_data` unchanged, in the same cycle it is presented. While that byte is stalled by `out_ready`, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Filter mode code |
| cfg_sap1 | input | 8 | First programmable value for the first address byte |
| cfg_sap2 | input | 8 | Second programmable value for the first address byte |
| cfg_tei1 | input | 8 | First programmable value for the second address byte |
| cfg_tei2 | input | 8 | Second programmable value for the second address byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_eof | input | 1 | Input byte is the last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the byte |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Forwarded byte ends its frame |
| out_status | output | 2 | Accepting comparator, on the last byte only |

## Verification
The assertions assume that the mode and the four address registers do not change while a frame is open. They also assume that a byte and its flags are held steady while `in_valid` is high and `in_ready` is low. The bench follows both rules: it reprograms the configuration only between frames, after an idle cycle. It drives each byte at a falling edge and keeps it until a rising edge at which `in_ready` was high. Back-pressure runs are made by toggling `out_ready` while a byte waits, which exercises the rule that a stall holds off the input.

// File: rtl/haf_pkg.sv
package haf_pkg;
  typedef enum logic [2:0] {FM_DROP, FM_ALL, FM_FIRST, FM_SECOND, FM_RAW} fmode_e;
  typedef enum logic [1:0] {HIT_NONE = 2'd0, HIT_A = 2'd1, HIT_B = 2'd2, HIT_GRP = 2'd3} hit_e;
  localparam logic [2:0] MC_RAW    = 3'b100;
  localparam logic [2:0] MC_SECOND = 3'b101;
  localparam logic [2:0] MC_ALL    = 3'b110;
  localparam logic [2:0] MC_FIRST  = 3'b111;
endpackage

// File: rtl/haf_mode_decode.sv
module haf_mode_decode
  import haf_pkg::*;
#(
  parameter int POS_W = 2
) (
  input  logic [2:0]       mode_code,
  output fmode_e           fmode,
  output logic [POS_W-1:0] cmp_pos,
  output logic             filtering
);
  always_comb begin
    unique case (mode_code)
      MC_RAW:    fmode = FM_RAW;
      MC_ALL:    fmode = FM_ALL;
      MC_FIRST:  fmode = FM_FIRST;
      MC_SECOND: fmode = FM_SECOND;
      default:   fmode = FM_DROP;
    endcase
  end

  // Position of the compared byte within the frame (0 = start byte)
  assign cmp_pos   = (fmode == FM_SECOND) ? POS_W'(1) : '0;
  assign filtering = (fmode == FM_FIRST) || (fmode == FM_SECOND);
endmodule

// File: rtl/haf_addr_match.sv
module haf_addr_match
  import haf_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] G_FIRST0 = 8'hFE,
  parameter logic [DW-1:0] G_FIRST1 = 8'hFC,
  parameter logic [DW-1:0] G_SECOND = 8'hFF
) (
  input  fmode_e        fmode,
  input  logic [DW-1:0] dat,
  input  logic [DW-1:0] sap_a,
  input  logic [DW-1:0] sap_b,
  input  logic [DW-1:0] tei_a,
  input  logic [DW-1:0] tei_b,
  output hit_e          hit
);
  localparam int NPROG = 2;

  logic [DW-1:0]    prog_ref [NPROG];
  logic [NPROG-1:0] prog_eq;
  logic             grp_eq;

  always_comb begin
    if (fmode == FM_SECOND) begin
      prog_ref[0] = tei_a;
      prog_ref[1] = tei_b;
      grp_eq      = (dat == G_SECOND);
    end else begin
      prog_ref[0] = sap_a;
      prog_ref[1] = sap_b;
      grp_eq      = (dat == G_FIRST0) || (dat == G_FIRST1);
    end
  end

  for (genvar i = 0; i < NPROG; i++) begin : g_cmp
    assign prog_eq[i] = (dat == prog_ref[i]);
  end

  // Fixed priority: first register, then second, then group
  always_comb begin
    if (prog_eq[0])      hit = HIT_A;
    else if (prog_eq[1]) hit = HIT_B;
    else if (grp_eq)     hit = HIT_GRP;
    else                 hit = HIT_NONE;
  end
endmodule

// File: rtl/haf_frame_track.sv
module haf_frame_track
  import haf_pkg::*;
#(
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic             filtering,
  input  logic [POS_W-1:0] cmp_pos,
  input  hit_e             hit,
  output logic [POS_W-1:0] idx,
  output logic             open_q,
  output logic             pass_q,
  output hit_e             code_q
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;

  assign idx = sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      open_q <= 1'b0;
      pass_q <= 1'b0;
      code_q <= HIT_NONE;
    end else if (beat) begin
      if (sof) begin
        open_q <= !eof;
        pass_q <= 1'b0;
        code_q <= HIT_NONE;
      end else if (eof) begin
        open_q <= 1'b0;
      end
      if (sof || open_q) begin
        pos_q <= (idx == POS_MAX) ? idx : idx + 1'b1;
        if (filtering && idx == cmp_pos) begin
          pass_q <= (hit != HIT_NONE);
          code_q <= hit;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import haf_pkg::*;
#(
  parameter int             DW        = 8,
  parameter int             POS_W     = 2,
  parameter logic [DW-1:0]  GRP_SAP_0 = 8'hFE,
  parameter logic [DW-1:0]  GRP_SAP_1 = 8'hFC,
  parameter logic [DW-1:0]  GRP_TEI   = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_mode,
  input  logic [DW-1:0] cfg_sap1,
  input  logic [DW-1:0] cfg_sap2,
  input  logic [DW-1:0] cfg_tei1,
  input  logic [DW-1:0] cfg_tei2,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [1:0]    out_status
);
  fmode_e           fmode;
  logic [POS_W-1:0] cmp_pos;
  logic             filtering;
  hit_e             hit;
  logic [POS_W-1:0] idx;
  logic             open_q;
  logic             pass_q;
  hit_e             code_q;
  logic             fwd_now;

  haf_mode_decode #(.POS_W(POS_W)) u_dec (
    .mode_code (cfg_mode),
    .fmode     (fmode),
    .cmp_pos   (cmp_pos),
    .filtering (filtering)
  );

  haf_addr_match #(
    .DW(DW), .G_FIRST0(GRP_SAP_0), .G_FIRST1(GRP_SAP_1), .G_SECOND(GRP_TEI)
  ) u_match (
    .fmode (fmode),
    .dat   (in_data),
    .sap_a (cfg_sap1),
    .sap_b (cfg_sap2),
    .tei_a (cfg_tei1),
    .tei_b (cfg_tei2),
    .hit   (hit)
  );

  haf_frame_track #(.POS_W(POS_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (in_valid && in_ready),
    .sof       (in_sof),
    .eof       (in_eof),
    .filtering (filtering),
    .cmp_pos   (cmp_pos),
    .hit       (hit),
    .idx       (idx),
    .open_q    (open_q),
    .pass_q    (pass_q),
    .code_q    (code_q)
  );

  always_comb begin
    unique case (fmode)
      FM_RAW:               fwd_now = 1'b1;
      FM_ALL:               fwd_now = in_sof || open_q;
      FM_FIRST, FM_SECOND:  fwd_now = !in_sof && open_q && pass_q && (idx > cmp_pos);
      default:              fwd_now = 1'b0;
    endcase
  end

  assign out_valid  = in_valid && fwd_now;
  assign in_ready   = fwd_now ? out_ready : 1'b1;
  assign out_data   = in_data;
  assign out_last   = (fmode != FM_RAW) && in_eof;
  assign out_status = (filtering && in_eof) ? code_q : HIT_NONE;
endmodule

// File: rtl/haf_checker.sv
module haf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_mode,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       in_eof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic [1:0] out_status
);
  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && out_data == in_data && in_ready == out_ready));

  assert_drop_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> in_ready);

  assert_unlisted_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[2] == 1'b0) |-> !out_valid);

  assert_raw_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b100 && in_valid) |-> (out_valid && !out_last && out_status == 2'b00));

  assert_first_byte_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b111 && in_valid && in_sof) |-> !out_valid);

  assert_first_byte_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b101 && in_valid && in_sof) |-> !out_valid);

  assert_all_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b110 && in_valid && in_sof) |-> (out_valid && out_status == 2'b00 && out_last == in_eof));

  assert_status_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> out_status == 2'b00);

  assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && (cfg_mode == 3'b111 || cfg_mode == 3'b101)) |-> out_status != 2'b00);
endmodule

bind hdlc_addr_filter haf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .in_sof(in_sof), .in_eof(in_eof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .out_status(out_status)
);

// File: tb/hdlc_addr_filter_bench.sv
module hdlc_addr_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'b110;
  logic [7:0] cfg_sap1 = 8'h10, cfg_sap2 = 8'h20, cfg_tei1 = 8'h31, cfg_tei2 = 8'h42;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_last;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic [1:0] out_status;

  int   n_checks = 0, n_errors = 0;
  bit   finished = 0;
  bit   bp = 0, tog = 0;
  int   stall_checks = 0;
  logic [7:0] frm [16];
  logic [7:0] cap_d [64];
  logic       cap_l [64];
  logic [1:0] cap_s [64];
  int   cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_addr_filter u_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_sap1(cfg_sap1), .cfg_sap2(cfg_sap2), .cfg_tei1(cfg_tei1), .cfg_tei2(cfg_tei2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_status(out_status)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    bit done = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    while (!done) begin
      out_ready = bp ? tog : 1'b1;
      tog = ~tog;
      #1;
      if (out_valid && !out_ready) begin
        stall_checks++;
        chk(in_ready == 1'b0, "R10", "in_ready during stall", in_ready, 0);
      end
      if (out_valid && out_ready && cap_n < 64) begin
        cap_d[cap_n] = out_data; cap_l[cap_n] = out_last; cap_s[cap_n] = out_status;
        cap_n++;
      end
      done = in_ready;
      @(posedge clk);
      if (!done) @(negedge clk);
    end
    #2;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    out_ready = 1'b1;
  endtask

  task automatic send_frame(input int n);
    cap_n = 0;
    for (int i = 0; i < n; i++) send_byte(frm[i], i == 0, i == n - 1);
  endtask

  // Expect frm[first..n-1] forwarded, last on final byte with status st
  task automatic check_cap(input string req, input int first, input int n, input logic [1:0] st);
    int bad = 0;
    chk(cap_n == n - first, req, "forwarded count", cap_n, n - first);
    if (cap_n == n - first) begin
      for (int i = 0; i < cap_n; i++) begin
        if (cap_d[i] != frm[first + i]) bad++;
        if (cap_l[i] != (i == cap_n - 1)) bad++;
        if (cap_s[i] != ((i == cap_n - 1) ? st : 2'b00)) bad++;
      end
      chk(bad == 0, req, "forwarded content/last/status mismatches", bad, 0);
    end
  endtask

  task automatic set_frm(input logic [7:0] a, b, c, d);
    frm[0] = a; frm[1] = b; frm[2] = c; frm[3] = d;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    cfg_mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    set_mode(3'b110);
    cap_n = 0;
    send_byte(8'h5A, 1'b0, 1'b0);
    chk(cap_n == 0, "R9", "byte with no open frame forwarded", cap_n, 0);
  endtask

  task automatic t_all();
    set_mode(3'b110);
    set_frm(8'h01, 8'h02, 8'h03, 8'h04);
    send_frame(4);
    check_cap("R1", 0, 4, 2'b00);
    cap_n = 0;
    send_byte(8'h77, 1'b0, 1'b0);
    chk(cap_n == 0, "R9", "stray byte after end forwarded", cap_n, 0);
  endtask

  task automatic t_first();
    set_mode(3'b111);
    set_frm(8'h10, 8'hA1, 8'hA2, 8'hA3); send_frame(4); check_cap("R2", 1, 4, 2'b01);
    set_frm(8'h20, 8'hB1, 8'hB2, 8'hB3); send_frame(4); check_cap("R5", 1, 4, 2'b10);
    set_frm(8'hFE, 8'hC1, 8'hC2, 8'hC3); send_frame(4); check_cap("R5", 1, 4, 2'b11);
    set_frm(8'hFC, 8'hD1, 8'hD2, 8'hD3); send_frame(3); check_cap("R2", 1, 3, 2'b11);
    set_frm(8'h11, 8'hE1, 8'hE2, 8'hE3); send_frame(4); check_cap("R4", 4, 4, 2'b00);
    set_frm(8'h10, 8'h00, 8'h00, 8'h00); send_frame(1); check_cap("R6", 1, 1, 2'b00);
  endtask

  task automatic t_priority();
    set_mode(3'b111);
    cfg_sap1 = 8'hFE; cfg_sap2 = 8'hFE;
    set_frm(8'hFE, 8'h61, 8'h62, 8'h63); send_frame(3); check_cap("R5", 1, 3, 2'b01);
    set_mode(3'b111);
    cfg_sap1 = 8'h10; cfg_sap2 = 8'hFC;
    set_frm(8'hFC, 8'h71, 8'h72, 8'h73); send_frame(3); check_cap("R5", 1, 3, 2'b10);
    set_mode(3'b111);
    cfg_sap2 = 8'h20;
  endtask

  task automatic t_second();
    set_mode(3'b101);
    set_frm(8'h99, 8'h31, 8'h81, 8'h82); send_frame(4); check_cap("R3", 2, 4, 2'b01);
    set_frm(8'h31, 8'h42, 8'h83, 8'h84); send_frame(4); check_cap("R3", 2, 4, 2'b10);
    set_frm(8'h00, 8'hFF, 8'h85, 8'h86); send_frame(3); check_cap("R5", 2, 3, 2'b11);
    set_frm(8'h31, 8'h30, 8'h87, 8'h88); send_frame(4); check_cap("R4", 4, 4, 2'b00);
    set_frm(8'h31, 8'h31, 8'h00, 8'h00); send_frame(1); check_cap("R6", 1, 1, 2'b00);
    set_frm(8'h99, 8'h31, 8'h00, 8'h00); send_frame(2); check_cap("R6", 2, 2, 2'b00);
  endtask

  task automatic t_raw();
    int bad = 0;
    set_mode(3'b100);
    cap_n = 0;
    for (int i = 0; i < 6; i++) send_byte(8'(8'h40 + i), i[0], i[1]);
    chk(cap_n == 6, "R7", "raw forwarded count", cap_n, 6);
    for (int i = 0; i < cap_n; i++)
      if (cap_d[i] != 8'(8'h40 + i) || cap_l[i] != 1'b0 || cap_s[i] != 2'b00) bad++;
    chk(bad == 0, "R7", "raw content/last/status mismatches", bad, 0);
  endtask

  task automatic t_unlisted();
    set_mode(3'b000);
    set_frm(8'h10, 8'h01, 8'h02, 8'h03);
    send_frame(4);
    chk(cap_n == 0, "R8", "mode 000 forwarded count", cap_n, 0);
    set_mode(3'b011);
    send_frame(4);
    chk(cap_n == 0, "R8", "mode 011 forwarded count", cap_n, 0);
  endtask

  task automatic t_backpressure();
    set_mode(3'b111);
    bp = 1; tog = 0; stall_checks = 0;
    set_frm(8'h10, 8'h91, 8'h92, 8'h93);
    send_frame(4);
    bp = 0;
    check_cap("R10", 1, 4, 2'b01);
    chk(stall_checks > 0, "R10", "stall cycles observed", stall_checks, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_all();
    t_first();
    t_priority();
    t_second();
    t_raw();
    t_unlisted();
    t_backpressure();
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule